// File: doc/BRIEF.md
# Blanked Crest-Factor Overcurrent Detector

This block guards a resonant half-bridge against inductor saturation. It receives digitized samples of the switching-node voltage, which stands for the low-side switch current, together with the state of the low-side gate drive. Only samples taken while the low-side switch is on, and after a programmable blanking delay from the moment it turned on, are treated as valid. The blanking delay hides the ringing that follows the turn-on edge.

Each low-side on interval contributes the mean of its first few valid samples to an exponential moving average. A valid sample larger than five times that average is taken as a saturation spike. The ratio of peak to average does not depend on the on-resistance of the sensing switch, so no fixed threshold needs trimming. The fault is raised only while the controller reports run mode. It then stays latched until the mode controller clears it.

A status output shows when five times the average no longer fits in the sample range. In that condition the detector cannot see a spike, and the controller may take action.

Top module: `cfd_crest_detector`

## Requirements
- R1: After a synchronous reset, `fault`, `range_hi` and `avg_level` are all zero.
- R2: A sample is valid only if `lo_on` is 1 and at least BLANK_CYC clocks have passed since the rise cycle. The rise cycle is the first cycle in which `lo_on` is 1 after a cycle with 0, or after reset, and counts as 0. A sample inside the blanking interval never raises the fault.
- R3: Samples presented while `lo_on` is 0 never raise the fault.
- R4: Only the first 2^MEAN_LOG2 valid samples (those with `smp_vld` = 1) of an on interval are summed. If an interval ends with fewer than that many, the average is left unchanged.
- R5: The average is updated in the first cycle with `lo_on` = 0 after an interval that collected a full set of samples. The update is acc := acc − (acc >> AVG_SHIFT) + (sum >> MEAN_LOG2), and `avg_level` = acc >> AVG_SHIFT, visible after that clock edge. At no other time does `avg_level` change.
- R6: With `run_mode` = 1, a valid sample whose value is strictly greater than 5 × `avg_level` sets `fault` on the next clock edge. A sample equal to 5 × `avg_level` does not set it.
- R7: While `run_mode` = 0 no fault is raised. The average is still updated.
- R8: `fault` stays at 1 until `clr_fault` is 1 at a clock edge. A detection in the same cycle as the clear wins, and `fault` stays 1.
- R9: `range_hi` is 1 exactly when 5 × `avg_level` > 2^DW − 1. It is updated together with `avg_level`.
- R10: The 5× product is formed without wraparound. While `range_hi` is 1, even the largest sample value does not raise the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 while the controller is in run mode; enables detection |
| lo_on | input | 1 | Low-side gate drive state, 1 = switch on |
| smp_vld | input | 1 | A new current sample is present on `smp_data` |
| smp_data | input | DW | Unsigned current sample |
| clr_fault | input | 1 | Synchronous clear of the latched fault |
| fault | output | 1 | Latched crest-factor overcurrent fault |
| range_hi | output | 1 | Five times the average exceeds the sample range |
| avg_level | output | DW | Current moving average of the interval means |

## Verification
On every cycle the assertions check five things:
- a fault can only appear after a valid, unblanked low-side sample taken in run mode;
- a fault is never raised while `range_hi` is set;
- the fault holds until it is cleared;
- `range_hi` always agrees with `avg_level`;
- the average moves only on the cycle after a low-side falling edge.

Only the bench scenarios can show some of the behaviour:
- the exact numeric values of the moving average;
- the strict comparison at exactly five times the average;
- the rule that short intervals are dropped from averaging;
- the priority of a detection over a clear in the same cycle.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  // Extra bits needed to hold five times a value without wraparound.
  localparam int unsigned X5_GUARD = 3;

  function automatic int unsigned scaled_width(input int unsigned w);
    return w + X5_GUARD;
  endfunction
endpackage

// File: rtl/cfd_blanker.sv
module cfd_blanker #(
  parameter int BLANK_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic lo_on,
  output logic rise,
  output logic fall,
  output logic win
);
  logic lo_q;

  always_ff @(posedge clk) begin
    if (rst) lo_q <= 1'b0;
    else     lo_q <= lo_on;
  end

  assign rise = lo_on & ~lo_q;
  assign fall = ~lo_on & lo_q;

  generate
    if (BLANK_CYC == 0) begin : g_noblank
      assign win = lo_on;
    end else begin : g_blank
      localparam int BW = $clog2(BLANK_CYC + 1);
      localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC - 1);
      logic [BW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)                        cnt <= '0;
        else if (rise)                  cnt <= LOAD;
        else if (lo_on && cnt != '0)    cnt <= cnt - BW'(1);
      end

      assign win = lo_on & ~rise & (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/cfd_cycle_mean.sv
module cfd_cycle_mean #(
  parameter int DW        = 10,
  parameter int MEAN_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          fall,
  input  logic          take,
  input  logic [DW-1:0] data,
  output logic          mean_vld,
  output logic [DW-1:0] mean
);
  localparam int CW = MEAN_LOG2 + 1;
  localparam int SW = DW + MEAN_LOG2;
  localparam logic [CW-1:0] NFULL = CW'(1 << MEAN_LOG2);

  logic [CW-1:0] cnt, cnt_base;
  logic [SW-1:0] sum, sum_base;
  logic          full;

  assign cnt_base = rise ? '0 : cnt;
  assign sum_base = rise ? '0 : sum;
  assign full     = (cnt == NFULL);

  always_ff @(posedge clk) begin
    if (rst || fall) begin
      cnt <= '0;
      sum <= '0;
    end else if (take && cnt_base != NFULL) begin
      cnt <= cnt_base + CW'(1);
      sum <= sum_base + SW'(data);
    end else begin
      cnt <= cnt_base;
      sum <= sum_base;
    end
  end

  assign mean_vld = fall & full;
  assign mean     = DW'(sum >> MEAN_LOG2);
endmodule

// File: rtl/cfd_ema.sv
module cfd_ema #(
  parameter int DW    = 10,
  parameter int SHIFT = 4,
  localparam int XW   = cfd_pkg::scaled_width(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [DW-1:0] mean,
  output logic [DW-1:0] avg_level,
  output logic [XW-1:0] avg_x5,
  output logic          range_hi
);
  localparam int AW = DW + SHIFT;
  localparam logic [XW-1:0] CEIL = XW'((1 << DW) - 1);

  logic [AW-1:0] acc, acc_nxt;
  logic [DW-1:0] avg_nxt;
  logic [XW-1:0] x5_nxt;

  always_comb begin
    acc_nxt = acc - (acc >> SHIFT) + AW'(mean);
    avg_nxt = DW'(acc_nxt >> SHIFT);
    x5_nxt  = (XW'(avg_nxt) << 2) + XW'(avg_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      avg_level <= '0;
      avg_x5    <= '0;
      range_hi  <= 1'b0;
    end else if (upd) begin
      acc       <= acc_nxt;
      avg_level <= avg_nxt;
      avg_x5    <= x5_nxt;
      range_hi  <= (x5_nxt > CEIL);
    end
  end
endmodule

// File: rtl/cfd_fault_latch.sv
module cfd_fault_latch #(
  parameter int DW  = 10,
  localparam int XW = cfd_pkg::scaled_width(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [DW-1:0] data,
  input  logic [XW-1:0] avg_x5,
  input  logic          clr,
  output logic          fault
);
  logic hit;

  assign hit = arm & (XW'(data) > avg_x5);

  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= hit | (fault & ~clr);
  end
endmodule

// File: rtl/cfd_crest_detector.sv
module cfd_crest_detector #(
  parameter int DW        = 10,
  parameter int BLANK_CYC = 125,
  parameter int MEAN_LOG2 = 2,
  parameter int AVG_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_mode,
  input  logic          lo_on,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          clr_fault,
  output logic          fault,
  output logic          range_hi,
  output logic [DW-1:0] avg_level
);
  localparam int XW = cfd_pkg::scaled_width(DW);

  logic          rise, fall, win, take;
  logic          mean_vld;
  logic [DW-1:0] mean;
  logic [XW-1:0] avg_x5;

  cfd_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .lo_on(lo_on),
    .rise(rise), .fall(fall), .win(win)
  );

  assign take = win & smp_vld;

  cfd_cycle_mean #(.DW(DW), .MEAN_LOG2(MEAN_LOG2)) u_mean (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .take(take),
    .data(smp_data), .mean_vld(mean_vld), .mean(mean)
  );

  cfd_ema #(.DW(DW), .SHIFT(AVG_SHIFT)) u_ema (
    .clk(clk), .rst(rst), .upd(mean_vld), .mean(mean),
    .avg_level(avg_level), .avg_x5(avg_x5), .range_hi(range_hi)
  );

  cfd_fault_latch #(.DW(DW)) u_fault (
    .clk(clk), .rst(rst), .arm(take & run_mode), .data(smp_data),
    .avg_x5(avg_x5), .clr(clr_fault), .fault(fault)
  );
endmodule

// File: rtl/cfd_crest_detector_chk.sv
module cfd_crest_detector_chk #(
  parameter int DW        = 10,
  parameter int BLANK_CYC = 125
) (
  input logic          clk,
  input logic          rst,
  input logic          run_mode,
  input logic          lo_on,
  input logic          smp_vld,
  input logic          clr_fault,
  input logic          fault,
  input logic          range_hi,
  input logic [DW-1:0] avg_level
);
  logic lo_seen;
  int   since_q, since_now;
  logic win_q;

  always_comb begin
    if (lo_on && !lo_seen)       since_now = 0;
    else if (since_q < BLANK_CYC) since_now = since_q + 1;
    else                         since_now = since_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_seen <= 1'b0;
      since_q <= 0;
      win_q   <= 1'b0;
    end else begin
      lo_seen <= lo_on;
      since_q <= since_now;
      win_q   <= lo_on && (since_now >= BLANK_CYC);
    end
  end

  assert_unblanked_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> win_q);

  assert_lo_high_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(lo_on));

  assert_avg_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(avg_level) |-> (!$past(lo_on) && $past(lo_on, 2)));

  assert_sample_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(smp_vld));

  assert_run_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(run_mode));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (fault && !clr_fault) |=> fault);

  assert_range_flag_R9: assert property (@(posedge clk) disable iff (rst)
    range_hi == (((DW + 3)'(avg_level) * (DW + 3)'(5)) > (DW + 3)'((1 << DW) - 1)));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> !$past(range_hi));
endmodule

bind cfd_crest_detector cfd_crest_detector_chk #(.DW(DW), .BLANK_CYC(BLANK_CYC)) u_chk (
  .clk(clk), .rst(rst), .run_mode(run_mode), .lo_on(lo_on), .smp_vld(smp_vld),
  .clr_fault(clr_fault), .fault(fault), .range_hi(range_hi), .avg_level(avg_level)
);

// File: tb/test_cfd_crest_detector.sv
`timescale 1ns/1ps
module test_cfd_crest_detector;
  localparam int DW    = 10;
  localparam int BLANK = 6;
  localparam int ML2   = 2;
  localparam int SH    = 4;
  localparam int NSMP  = 1 << ML2;
  localparam int MAXV  = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_mode = 1'b0, lo_on = 1'b0, smp_vld = 1'b0, clr_fault = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          fault, range_hi;
  logic [DW-1:0] avg_level;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfd_crest_detector #(.DW(DW), .BLANK_CYC(BLANK), .MEAN_LOG2(ML2), .AVG_SHIFT(SH)) i_cfd_crest_detector (
    .clk(clk), .rst(rst), .run_mode(run_mode), .lo_on(lo_on), .smp_vld(smp_vld),
    .smp_data(smp_data), .clr_fault(clr_fault), .fault(fault), .range_hi(range_hi),
    .avg_level(avg_level)
  );

  // Behavioural reference model
  int m_lo, m_since, m_cnt, m_sum, m_acc, m_avg, m_rng, m_fault;

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 0; m_since = 0; m_cnt = 0; m_sum = 0;
      m_acc = 0; m_avg = 0; m_rng = 0; m_fault = 0;
    end else begin
      bit rise_e, win_e, hit_e;
      rise_e = lo_on && (m_lo == 0);
      if (rise_e) begin m_since = 0; m_cnt = 0; m_sum = 0; end
      else if (lo_on) m_since = m_since + 1;
      win_e = lo_on && (m_since >= BLANK);
      hit_e = win_e && smp_vld && run_mode && (int'(smp_data) > 5 * m_avg);
      m_fault = (hit_e || (m_fault != 0 && !clr_fault)) ? 1 : 0;
      if (win_e && smp_vld && m_cnt < NSMP) begin
        m_sum = m_sum + int'(smp_data);
        m_cnt = m_cnt + 1;
      end
      if (!lo_on && m_lo != 0) begin
        if (m_cnt == NSMP) begin
          m_acc = m_acc - (m_acc >> SH) + (m_sum >> ML2);
          m_avg = m_acc >> SH;
          m_rng = (5 * m_avg > MAXV) ? 1 : 0;
        end
        m_cnt = 0; m_sum = 0;
      end
      m_lo = lo_on ? 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 cycle fault", int'(fault), m_fault);
      chk("R5 cycle avg_level", int'(avg_level), m_avg);
      chk("R9 cycle range_hi", int'(range_hi), m_rng);
    end
  end

  task automatic pulse(input int on_len, input int off_len, input int base,
                       input int spike_pos, input int spike_val,
                       input int off_val, input bit clr_at_spike);
    for (int k = 0; k < on_len; k++) begin
      @(negedge clk);
      lo_on     = 1'b1;
      smp_vld   = 1'b1;
      smp_data  = DW'((k == spike_pos) ? spike_val : base);
      clr_fault = (k == spike_pos) && clr_at_spike;
    end
    for (int k = 0; k < off_len; k++) begin
      @(negedge clk);
      lo_on     = 1'b0;
      clr_fault = 1'b0;
      smp_vld   = (off_val >= 0);
      smp_data  = DW'((off_val >= 0) ? off_val : 0);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    smp_data = '0;
  endtask

  task automatic clear_fault();
    @(negedge clk); clr_fault = 1'b1;
    @(negedge clk); clr_fault = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset fault", int'(fault), 0);
    chk("R1 reset range_hi", int'(range_hi), 0);
    chk("R1 reset avg_level", int'(avg_level), 0);
    rst = 1'b0;

    // R5: first full interval of 100s: acc=100, avg=100>>4=6
    pulse(16, 10, 100, -1, 0, -1, 0);
    chk("R5 first update", int'(avg_level), 6);

    // R4: only 3 valid samples -> no update
    pulse(BLANK + 3, 10, 500, -1, 0, -1, 0);
    chk("R4 short interval keeps avg", int'(avg_level), 6);

    // R7: sweep mode with spikes
    for (int i = 0; i < 40; i++) pulse(16, 10, 100, 12, MAXV, -1, 0);
    chk("R7 no fault in sweep", int'(fault), 0);
    chk("R5 avg after sweep", int'(avg_level), m_avg);

    run_mode = 1'b1;
    // R2: spikes inside blanking
    pulse(16, 10, 100, 2, MAXV, -1, 0);
    chk("R2 spike early in blanking", int'(fault), 0);
    pulse(16, 10, 100, BLANK - 1, MAXV, -1, 0);
    chk("R2 spike on last blanked cycle", int'(fault), 0);
    // R3: spikes while low side off
    pulse(16, 10, 100, -1, 0, MAXV, 0);
    chk("R3 spike with lo off", int'(fault), 0);

    // R6: equal does not trip, one above does
    pulse(16, 10, 100, 12, 5 * m_avg, -1, 0);
    chk("R6 equal to 5x avg", int'(fault), 0);
    pulse(16, 10, 100, 12, 5 * m_avg + 1, -1, 0);
    chk("R6 above 5x avg", int'(fault), 1);

    // R8: sticky then clear
    repeat (5) @(negedge clk);
    chk("R8 fault held", int'(fault), 1);
    clear_fault();
    chk("R8 fault cleared", int'(fault), 0);
    pulse(16, 10, 100, 12, 5 * m_avg + 10, -1, 1);
    chk("R8 detect wins over clear", int'(fault), 1);
    clear_fault();
    chk("R8 cleared again", int'(fault), 0);

    // R9/R10: drive average high
    run_mode = 1'b0;
    for (int i = 0; i < 60; i++) pulse(16, 10, 1000, -1, 0, -1, 0);
    chk("R9 range_hi set", int'(range_hi), 1);
    run_mode = 1'b1;
    pulse(16, 10, 1000, 12, MAXV, -1, 0);
    chk("R10 no fault when saturated", int'(fault), 0);
    run_mode = 1'b0;
    for (int i = 0; i < 60; i++) pulse(16, 10, 40, -1, 0, -1, 0);
    chk("R9 range_hi cleared", int'(range_hi), 0);
    chk("R5 avg after descent", int'(avg_level), m_avg);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule